// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block moves 36-bit words in one direction between two clock domains that are not related. The writer and the reader each have their own clock, an active-low select and an active-high enable. A word moves only on a rising edge of the port's own clock when that port is selected and enabled. The write side's ready flag acts as the `ready` of a valid/ready pair: a word offered while the flag is LOW is dropped. The sender must keep the word and offer it again once the flag returns HIGH. On the read side in fall-through mode, the read flag is `valid` and a selected, enabled strobe is `ready`.

Each side also reports an active-low almost-empty or almost-full flag. The threshold for each flag comes from an offset input that is compared at run time. The static mode input picks the read behaviour:
- **Standard mode** (mode HIGH): the read flag means "memory not empty", and the word comes out on the clock edge that takes the strobe.
- **Fall-through mode** (mode LOW): the head word is moved to the output register without a strobe, the read flag means "word on the outputs", and a strobe consumes that word.

The pointers cross between the domains as Gray code through two-flop synchronizers. Each flag is therefore computed only from registers in its own port's domain. A two-way link is built from two instances of this block. The pad drivers are outside the block and use the read-side output-enable.

Top module: `dcfifo_top`

## Requirements
- R1: A write happens on a rising `wr_clk` edge only when `wr_sel_n` is 0, `wr_en` is 1 and `wr_rdy` is 1. A read strobe counts only when `rd_sel_n` is 0 and `rd_en` is 1. An unselected or disabled port changes nothing.
- R2: The block ignores a write offered while `wr_rdy` is 0, which means the memory holds DEPTH words. It also ignores a read strobe while `rd_flag` is 0. In both cases no word is lost, duplicated or added.
- R3: Words come out in the order they were written, with their values unchanged.
- R4: In standard mode (`std_mode` = 1):
  - `rd_flag` is 1 exactly when the memory holds at least one word.
  - An accepted strobe puts the oldest word on `rd_data` at that same `rd_clk` edge.
  - Without an accepted strobe, `rd_data` holds its value.
- R5: In fall-through mode (`std_mode` = 0):
  - The oldest word is shown on `rd_data` without any strobe, and `rd_flag` = 1 marks it as valid.
  - A strobe consumes that word, and the next word appears at the same edge.
  - While no strobe is given, the shown word stays stable.
- R6: `rd_ae_n` is 0 when the number of stored words is less than or equal to `ae_ofs`, and 1 otherwise. In fall-through mode the stored words include the word shown on `rd_data`.
- R7: `wr_af_n` is 0 when the number of free memory locations is less than or equal to `af_ofs`, and 1 otherwise.
- R8: `rd_oe` is 1 exactly while `rd_sel_n` is 0.
- R9: After reset:
  - `wr_rdy` = 1, `wr_af_n` = 1.
  - `rd_flag` = 0, `rd_ae_n` = 0.
  - `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_sel_n | input | 1 | Write port select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | 36 | Word to write |
| wr_rdy | output | 1 | HIGH when there is room to write (LOW = full) |
| wr_af_n | output | 1 | Almost-full flag, active low |
| af_ofs | input | PTR_W | Almost-full offset in free locations |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_sel_n | input | 1 | Read port select, active low |
| rd_en | input | 1 | Read enable, active high |
| rd_data | output | 36 | Read word register |
| rd_oe | output | 1 | Output-enable for an external bus driver |
| rd_flag | output | 1 | Standard: not empty; fall-through: output ready |
| rd_ae_n | output | 1 | Almost-empty flag, active low |
| ae_ofs | input | PTR_W | Almost-empty offset in stored words |
| std_mode | input | 1 | 1 = standard mode, 0 = fall-through mode; held static |

## Verification
The hardest case to reach from the ports is a write offered while the memory is full. The write side only sees the memory as full after all DEPTH words have been written, and the read pointer has to be quiet long enough for its synchronized copy to have settled. The bench fills the memory and waits several cycles of both clocks before offering one extra word with a value that no other write uses. It then drains the memory and checks that exactly DEPTH words come out in order and that the extra value never appears. Fall-through mode is reached through a reset with the mode input LOW. A strobe given while nothing is ready is then shown to leave the next written word as the first word out.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int unsigned WORD_W = 36;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int unsigned W     = 36,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata <= '0;
    else if (re)  rdata <= store[raddr];
  end
endmodule

// File: rtl/dcfifo_wctl.sv
module dcfifo_wctl
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          en,
  input  logic [PW-1:0] rgray_s,
  input  logic [PW-1:0] af_ofs,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] used,
  output logic          rdy,
  output logic          af_n
);
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] free_cnt;
  logic [31:0]   rbin_wide;
  logic [31:0]   gray_wide;

  assign rbin_wide = gray_to_bin(32'(rgray_s));
  assign rbin_s    = rbin_wide[PW-1:0];
  assign used      = wbin - rbin_s;
  assign free_cnt  = PW'(DEPTH) - used;
  assign rdy       = (used != PW'(DEPTH));
  assign af_n      = !(free_cnt <= af_ofs);
  assign we        = !sel_n && en && rdy;
  assign waddr     = wbin[AW-1:0];
  assign gray_wide = bin_to_gray(32'(wbin + PW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin + PW'(1);
      wgray <= gray_wide[PW-1:0];
    end
  end
endmodule

// File: rtl/dcfifo_rctl.sv
module dcfifo_rctl
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std_mode,
  input  logic          sel_n,
  input  logic          en,
  input  logic [PW-1:0] wgray_s,
  input  logic [PW-1:0] ae_ofs,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic          flag,
  output logic          ae_n
);
  logic [PW-1:0] wbin_s;
  logic [PW-1:0] mem_cnt;
  logic [PW:0]   stored;
  logic          mem_empty;
  logic          strobe;
  logic          head_v;
  logic [31:0]   wbin_wide;
  logic [31:0]   gray_wide;

  assign wbin_wide = gray_to_bin(32'(wgray_s));
  assign wbin_s    = wbin_wide[PW-1:0];
  assign mem_cnt   = wbin_s - rbin;
  assign mem_empty = (mem_cnt == '0);
  assign strobe    = !sel_n && en;
  assign raddr     = rbin[AW-1:0];
  assign gray_wide = bin_to_gray(32'(rbin + PW'(1)));

  always_comb begin
    if (std_mode) begin
      re   = strobe && !mem_empty;
      flag = !mem_empty;
    end else begin
      re   = !mem_empty && (!head_v || strobe);
      flag = head_v;
    end
  end

  assign stored = {1'b0, mem_cnt} + ((!std_mode && head_v) ? (PW+1)'(1) : '0);
  assign ae_n   = !(stored <= {1'b0, ae_ofs});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      head_v <= 1'b0;
    end else begin
      if (re) begin
        rbin  <= rbin + PW'(1);
        rgray <= gray_wide[PW-1:0];
      end
      if (std_mode)    head_v <= 1'b0;
      else if (re)     head_v <= 1'b1;
      else if (strobe) head_v <= 1'b0;
    end
  end
endmodule

// File: rtl/dcfifo_top.sv
module dcfifo_top
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PTR_W = AW + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_sel_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_rdy,
  output logic              wr_af_n,
  input  logic [PTR_W-1:0]  af_ofs,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_sel_n,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              rd_flag,
  output logic              rd_ae_n,
  input  logic [PTR_W-1:0]  ae_ofs,
  input  logic              std_mode
);
  logic             we, re;
  logic [AW-1:0]    waddr, raddr;
  logic [PTR_W-1:0] wr_ptr_bin, wr_ptr_gray, rd_ptr_bin, rd_ptr_gray;
  logic [PTR_W-1:0] wgray_at_rd, rgray_at_wr;
  logic [PTR_W-1:0] wr_used;

  dcfifo_sync #(.W(PTR_W)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_ptr_gray), .q(wgray_at_rd));
  dcfifo_sync #(.W(PTR_W)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_ptr_gray), .q(rgray_at_wr));

  dcfifo_wctl #(.DEPTH(DEPTH)) u_wctl (
    .clk(wr_clk), .rst_n(wr_rst_n), .sel_n(wr_sel_n), .en(wr_en),
    .rgray_s(rgray_at_wr), .af_ofs(af_ofs), .we(we), .waddr(waddr),
    .wbin(wr_ptr_bin), .wgray(wr_ptr_gray), .used(wr_used),
    .rdy(wr_rdy), .af_n(wr_af_n));

  dcfifo_rctl #(.DEPTH(DEPTH)) u_rctl (
    .clk(rd_clk), .rst_n(rd_rst_n), .std_mode(std_mode), .sel_n(rd_sel_n),
    .en(rd_en), .wgray_s(wgray_at_rd), .ae_ofs(ae_ofs), .re(re),
    .raddr(raddr), .rbin(rd_ptr_bin), .rgray(rd_ptr_gray),
    .flag(rd_flag), .ae_n(rd_ae_n));

  dcfifo_mem #(.W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst_n(rd_rst_n), .re(re), .raddr(raddr),
    .rdata(rd_data));

  assign rd_oe = !rd_sel_n;
endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned PW    = 9,
  parameter int unsigned DW    = 36
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          wr_sel_n,
  input logic          wr_en,
  input logic          wr_rdy,
  input logic [PW-1:0] w_ptr,
  input logic [PW-1:0] w_used,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          rd_sel_n,
  input logic          rd_en,
  input logic          rd_flag,
  input logic          std_mode,
  input logic [PW-1:0] r_ptr,
  input logic [DW-1:0] rd_data
);
  // R2: write offered while full leaves the write pointer alone
  a_r2_no_overflow: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (!wr_sel_n && wr_en && !wr_rdy) |=> $stable(w_ptr));

  // R1: an accepted write advances the pointer by exactly one
  a_r1_write_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (!wr_sel_n && wr_en && wr_rdy) |=> (w_ptr == $past(w_ptr) + PW'(1)));

  // R2: occupancy seen by the writer never exceeds the depth
  a_r2_bound: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    w_used <= PW'(DEPTH));

  // R2: standard-mode strobe on empty leaves the read pointer alone
  a_r2_no_underflow: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (std_mode && !rd_sel_n && rd_en && !rd_flag) |=> $stable(r_ptr));

  // R4: no accepted strobe in standard mode, read word held
  a_r4_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (std_mode && !(!rd_sel_n && rd_en)) |=> $stable(rd_data));

  // R5: a shown word not consumed stays shown and valid
  a_r5_head_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!std_mode && rd_flag && !(!rd_sel_n && rd_en)) |=> ($stable(rd_data) && rd_flag));
endmodule

bind dcfifo_top dcfifo_chk #(.DEPTH(DEPTH), .PW(PTR_W), .DW(dcfifo_pkg::WORD_W)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_sel_n(wr_sel_n), .wr_en(wr_en),
  .wr_rdy(wr_rdy), .w_ptr(wr_ptr_bin), .w_used(wr_used),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_sel_n(rd_sel_n), .rd_en(rd_en),
  .rd_flag(rd_flag), .std_mode(std_mode), .r_ptr(rd_ptr_bin), .rd_data(rd_data));

// File: tb/dcfifo_top_tb_top.sv
module dcfifo_top_tb_top;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned PW    = $clog2(DEPTH) + 1;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst_n, rd_rst_n;
  logic          wr_sel_n, wr_en, rd_sel_n, rd_en, std_mode;
  logic [35:0]   wr_data;
  logic [PW-1:0] af_ofs, ae_ofs;
  logic          wr_rdy, wr_af_n, rd_oe, rd_flag, rd_ae_n;
  logic [35:0]   rd_data;
  int errors = 0;
  int checks = 0;

  always #4 wr_clk = ~wr_clk;      // 125 MHz
  always #5.5 rd_clk = ~rd_clk;

  dcfifo_top #(.DEPTH(DEPTH)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_sel_n(wr_sel_n), .wr_en(wr_en),
    .wr_data(wr_data), .wr_rdy(wr_rdy), .wr_af_n(wr_af_n), .af_ofs(af_ofs),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_sel_n(rd_sel_n), .rd_en(rd_en),
    .rd_data(rd_data), .rd_oe(rd_oe), .rd_flag(rd_flag), .rd_ae_n(rd_ae_n),
    .ae_ofs(ae_ofs), .std_mode(std_mode));

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    wr_sel_n = 1; wr_en = 0; rd_sel_n = 1; rd_en = 0; wr_data = '0;
    std_mode = mode; af_ofs = PW'(3); ae_ofs = PW'(2);
    wr_rst_n = 0; rd_rst_n = 0;
    repeat (3) @(negedge wr_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge wr_clk);
    repeat (6) @(negedge rd_clk);
  endtask

  task automatic push(input logic [35:0] v);
    @(negedge wr_clk);
    wr_sel_n = 0; wr_en = 1; wr_data = v;
    @(negedge wr_clk);
    wr_sel_n = 1; wr_en = 0;
  endtask

  // one strobe; at the following negedge the result is on rd_data
  task automatic strobe();
    @(negedge rd_clk);
    rd_sel_n = 0; rd_en = 1;
    @(negedge rd_clk);
    rd_sel_n = 1; rd_en = 0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1);
    check("R9 wr_rdy", wr_rdy, 1);
    check("R9 wr_af_n", wr_af_n, 1);
    check("R9 rd_flag", rd_flag, 0);
    check("R9 rd_ae_n", rd_ae_n, 0);
    check("R9 rd_data", rd_data, 0);
    check("R8 rd_oe idle", rd_oe, 0);
  endtask

  task automatic t_std_order();
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) push(36'hA000 + 36'(i));
    settle();
    check("R4 not empty", rd_flag, 1);
    for (int i = 0; i < 4; i++) begin
      strobe();
      check("R3 R4 order", rd_data, 36'hA000 + 36'(i));
    end
    settle();
    check("R4 empty after drain", rd_flag, 0);
    check("R4 held", rd_data, 36'hA003);
  endtask

  task automatic t_gating();
    do_reset(1'b1);
    @(negedge wr_clk); wr_sel_n = 1; wr_en = 1; wr_data = 36'h111;
    @(negedge wr_clk); wr_sel_n = 0; wr_en = 0;
    @(negedge wr_clk); wr_sel_n = 1;
    settle();
    check("R1 write gated", rd_flag, 0);
    push(36'h222);
    settle();
    @(negedge rd_clk); rd_sel_n = 1; rd_en = 1;
    @(negedge rd_clk); rd_sel_n = 0; rd_en = 0;
    #1 check("R8 rd_oe selected", rd_oe, 1);
    @(negedge rd_clk); rd_sel_n = 1;
    #1 check("R8 rd_oe released", rd_oe, 0);
    settle();
    check("R1 read gated flag", rd_flag, 1);
    check("R1 read gated data", rd_data, 0);
    strobe();
    check("R1 R3 word", rd_data, 36'h222);
  endtask

  task automatic t_empty_read();
    do_reset(1'b1);
    strobe();
    check("R2 empty read data", rd_data, 0);
    push(36'h55);
    settle();
    strobe();
    check("R2 empty read no skip", rd_data, 36'h55);
    settle();
    check("R2 empty read no extra", rd_flag, 0);
  endtask

  task automatic t_full();
    do_reset(1'b1);
    for (int i = 0; i < DEPTH; i++) push(36'h100 + 36'(i));
    settle();
    check("R2 full rdy", wr_rdy, 0);
    check("R7 full af", wr_af_n, 0);
    push(36'hBAD);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      strobe();
      check("R2 R3 full drain", rd_data, 36'h100 + 36'(i));
    end
    settle();
    check("R2 no extra word", rd_flag, 0);
    check("R2 rdy after drain", wr_rdy, 1);
  endtask

  task automatic t_almost();
    do_reset(1'b1);
    push(1); push(2);
    settle();
    check("R6 count 2 <= 2", rd_ae_n, 0);
    push(3);
    settle();
    check("R6 count 3 > 2", rd_ae_n, 1);
    for (int i = 0; i < 9; i++) push(36'(10 + i));
    settle();
    check("R7 free 4 > 3", wr_af_n, 1);
    push(99);
    settle();
    check("R7 free 3 <= 3", wr_af_n, 0);
    strobe();
    settle();
    check("R7 free 4 after read", wr_af_n, 1);
  endtask

  task automatic t_fwft();
    do_reset(1'b0);
    strobe();
    push(36'h11); push(36'h22);
    settle();
    check("R5 ready no strobe", rd_flag, 1);
    check("R5 R2 head word", rd_data, 36'h11);
    check("R6 fwft stored 2", rd_ae_n, 0);
    strobe();
    check("R5 next head", rd_data, 36'h22);
    check("R5 still ready", rd_flag, 1);
    strobe();
    check("R5 drained", rd_flag, 0);
    strobe();
    push(36'h33);
    settle();
    check("R5 R2 after idle strobe", rd_data, 36'h33);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset_state();
    t_std_order();
    t_gating();
    t_empty_read();
    t_full();
    t_almost();
    t_fwft();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule